// File: doc/BRIEF.md
# Look-Ahead Two's-Complement Adder-Subtractor

This block adds or subtracts two equal-width words in a single combinational pass. A mode bit selects the operation. In add mode the second operand passes through unchanged and the carry-in is zero. In subtract mode every bit of the second operand is inverted and the carry-in is forced to one, so the block forms the two's-complement difference on the same datapath.

Each bit position produces a propagate term and a generate term. Every internal carry, and the carry-out, is then written directly as a flat sum of products over those terms and the carry-in. No carry waits for the carry of the bit below it, so all internal carries come out of the same two-level structure and have equal depth.

Besides the result word, the block drives a carry-out and a signed overflow flag. In subtract mode the carry-out reads as "no borrow". There is no clock and no reset: the outputs follow the present inputs only.

Top module: `la_addsub`

## Requirements
- R1: With `op_sub` = 0, `{carry_out, result}` equals the unsigned sum `a + b` as a WIDTH+1 bit value.
- R2: With `op_sub` = 1, `result` equals `(a - b)` modulo 2^WIDTH.
- R3: With `op_sub` = 1, `carry_out` is 1 exactly when `a >= b` as unsigned numbers, and 0 when a borrow occurs.
- R4: `ovf` is 1 exactly when the signed (two's-complement) sum in add mode, or the signed difference in subtract mode, falls outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1. Otherwise it is 0.
- R5: In add mode with `b` = 0, `result` equals `a`, and `carry_out` and `ovf` are both 0.
- R6: In subtract mode with `a` equal to `b`, `result` is 0, `carry_out` is 1 and `ovf` is 0.
- R7: In subtract mode with `b` equal to the most negative value (only the MSB set), `ovf` is 1 exactly when the MSB of `a` is 0.
- R8: Each carry into bit i+1 equals the generate term of bit i OR'ed with the propagate term of bit i AND'ed with the carry into bit i. The outputs depend only on the present inputs, with no state between vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| result | output | WIDTH | Sum or difference modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the MSB; in subtract mode 1 means no borrow |
| ovf | output | 1 | Signed overflow flag |

## Verification
All three outputs are due in the same cycle in which the operands and mode are applied, with zero register stages. The bench drives each vector just after a rising edge and compares on the following falling edge, against an expected record it queued when it drove that vector. The sweep covers every combination of the two 4-bit operands and the mode bit. The checks for the corner-case requirements are tagged when the vector falls into that case.

// File: rtl/la_addsub_pkg.sv
package la_addsub_pkg;

   // Upper bound on word width; the flat carry terms grow with the square of the width.
   localparam int LA_MAX_WIDTH = 16;
   localparam int LA_MIN_WIDTH = 2;

   typedef enum logic {
      LA_OP_ADD = 1'b0,
      LA_OP_SUB = 1'b1
   } la_op_e;

endpackage

// File: rtl/la_operand_prep.sv
module la_operand_prep #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             sub_mode,
   output logic [WIDTH-1:0] opb_eff,
   output logic [WIDTH-1:0] prop,
   output logic [WIDTH-1:0] gen,
   output logic             cin
);
   import la_addsub_pkg::*;

   la_op_e op;
   assign op  = la_op_e'(sub_mode);
   assign cin = (op == LA_OP_SUB);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign opb_eff[i] = opb[i] ^ sub_mode;
      assign prop[i]    = opa[i] ^ opb_eff[i];
      assign gen[i]     = opa[i] & opb_eff[i];
   end

   // R2: in subtract mode the effective operand is the bitwise complement
   always_comb begin
      p_invert_r2: assert final (sub_mode ? (opb_eff == ~opb) : (opb_eff == opb))
         else $error("operand inversion mismatch");
   end

endmodule

// File: rtl/la_carry_gen.sv
module la_carry_gen #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] prop,
   input  logic [WIDTH-1:0] gen,
   input  logic             cin,
   output logic [WIDTH:0]   carry
);

   assign carry[0] = cin;

   // Each carry is an independent two-level sum of products over the
   // propagate/generate terms and the carry-in; no carry feeds another.
   for (genvar k = 0; k < WIDTH; k++) begin : g_carry
      logic c_flat;
      always_comb begin
         logic acc;
         logic prod;
         acc = 1'b0;
         for (int j = 0; j <= k; j++) begin
            prod = gen[j];
            for (int m = j + 1; m <= k; m++) begin
               prod = prod & prop[m];
            end
            acc = acc | prod;
         end
         prod = cin;
         for (int m = 0; m <= k; m++) begin
            prod = prod & prop[m];
         end
         c_flat = acc | prod;
      end
      assign carry[k+1] = c_flat;
   end

   // R8: the flat terms agree with the bit-to-bit carry recurrence
   always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
         p_carry_rec_r8: assert final (carry[i+1] == (gen[i] | (prop[i] & carry[i])))
            else $error("carry %0d disagrees with recurrence", i + 1);
      end
   end

endmodule

// File: rtl/la_sum_flags.sv
module la_sum_flags #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] prop,
   input  logic [WIDTH:0]   carry,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_sum
      assign sum[i] = prop[i] ^ carry[i];
   end

   assign cout = carry[WIDTH];
   assign ovf  = carry[WIDTH] ^ carry[WIDTH-1];

endmodule

// File: rtl/la_addsub.sv
module la_addsub #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             op_sub,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             ovf
);
   import la_addsub_pkg::*;

   localparam int MSB = WIDTH - 1;

   if (WIDTH < LA_MIN_WIDTH || WIDTH > LA_MAX_WIDTH) begin : g_width_chk
      $error("la_addsub: WIDTH %0d outside supported range", WIDTH);
   end

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] prop;
   logic [WIDTH-1:0] gen;
   logic             cin;
   logic [WIDTH:0]   carry;

   la_operand_prep #(.WIDTH(WIDTH)) u_prep (
      .opa      (a),
      .opb      (b),
      .sub_mode (op_sub),
      .opb_eff  (b_eff),
      .prop     (prop),
      .gen      (gen),
      .cin      (cin)
   );

   la_carry_gen #(.WIDTH(WIDTH)) u_carry (
      .prop  (prop),
      .gen   (gen),
      .cin   (cin),
      .carry (carry)
   );

   la_sum_flags #(.WIDTH(WIDTH)) u_sum (
      .prop  (prop),
      .carry (carry),
      .sum   (result),
      .cout  (carry_out),
      .ovf   (ovf)
   );

   always_comb begin
      // R1: add mode yields the full-width unsigned sum
      p_add_sum_r1: assert final (op_sub || ({carry_out, result} == ({1'b0, a} + {1'b0, b})))
         else $error("add result mismatch");
      // R2: subtract mode yields the modular difference
      p_sub_diff_r2: assert final (!op_sub || (result == WIDTH'(a - b)))
         else $error("subtract result mismatch");
      // R3: subtract carry-out means no borrow
      p_no_borrow_r3: assert final (!op_sub || (carry_out == (a >= b)))
         else $error("borrow indication mismatch");
      // R4: overflow flag tracks sign disagreement between operands and result
      p_ovf_sign_r4: assert final (ovf == ((a[MSB] == b_eff[MSB]) && (result[MSB] != a[MSB])))
         else $error("overflow flag mismatch");
   end

endmodule

// File: tb/la_addsub_tb.sv
module la_addsub_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 4;
   localparam int MASK       = (1 << W) - 1;
   localparam int HALF       = 1 << (W - 1);
   localparam int NVEC       = 1 << (2 * W + 1);

   typedef struct {
      int a;
      int b;
      int m;
      int res;
      int cy;
      int ov;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic         op_sub = 1'b0;
   logic [W-1:0] result;
   logic         carry_out;
   logic         ovf;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;
   exp_t expq[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   la_addsub #(.WIDTH(W)) dut_i (
      .a         (a),
      .b         (b),
      .op_sub    (op_sub),
      .result    (result),
      .carry_out (carry_out),
      .ovf       (ovf)
   );

   task automatic check(input string tag, input string what, input int act, input int exp, input exp_t e);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s a=%0d b=%0d m=%0d actual=%0d expected=%0d",
                  tag, what, e.a, e.b, e.m, act, exp);
      end
   endtask

   function automatic int to_signed(input int v);
      return (v >= HALF) ? v - (1 << W) : v;
   endfunction

   function automatic exp_t model(input int av, input int bv, input int mv);
      exp_t e;
      int   sr;
      e.a = av; e.b = bv; e.m = mv;
      if (mv == 0) begin
         e.res = (av + bv) & MASK;
         e.cy  = (av + bv) >> W;
         sr    = to_signed(av) + to_signed(bv);
      end else begin
         e.res = (av - bv) & MASK;
         e.cy  = (av >= bv) ? 1 : 0;
         sr    = to_signed(av) - to_signed(bv);
      end
      e.ov = (sr > HALF - 1 || sr < -HALF) ? 1 : 0;
      return e;
   endfunction

   // Compare on the falling edge: results are combinational, due in the drive cycle.
   always @(negedge clk) begin
      if (!rst && expq.size() > 0) begin
         exp_t e;
         string rt, ct, ot;
         e = expq.pop_front();
         rt = (e.m != 0) ? "R2" : "R1";
         ct = (e.m != 0) ? "R3" : "R1";
         ot = "R4";
         if (e.m == 0 && e.b == 0) begin rt = "R5"; ct = "R5"; ot = "R5"; end
         if (e.m != 0 && e.a == e.b) begin rt = "R6"; ct = "R6"; ot = "R6"; end
         if (e.m != 0 && e.b == HALF) ot = "R7";
         check(rt, "result", int'(result), e.res, e);
         check(ct, "carry_out", int'(carry_out), e.cy, e);
         check(ot, "ovf", int'(ovf), e.ov, e);
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // Reset-state vector: all-zero inputs give all-zero outputs
      for (int v = 0; v < NVEC; v++) begin
         @(posedge clk);
         #1;
         a      = W'(v & MASK);
         b      = W'((v >> W) & MASK);
         op_sub = v[2*W];
         expq.push_back(model(v & MASK, (v >> W) & MASK, (v >> (2 * W)) & 1));
      end
      // R8: re-apply earlier vectors; no state may carry over between them
      for (int v = 0; v < 8; v++) begin
         @(posedge clk);
         #1;
         a      = W'(v * 3);
         b      = W'(MASK - v);
         op_sub = v[0];
         expq.push_back(model((v * 3) & MASK, MASK - v, v & 1));
      end
      @(posedge clk);
      @(negedge clk);
      #1 done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 5000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog R8 actual=hung expected=complete");
      end
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule